// File: doc/BRIEF.md
# Two-Channel Interrupt Cause and Mask Unit

This block collects event pulses from several processing channels into one shared cause register and raises a per-channel interrupt line when any event that software has enabled is pending. Each channel owns one equal-width field of the shared cause register and the same field of a shared mask register, so a single register access can touch every channel at once.

Event inputs set cause bits. Software acknowledges events by writing the cause register, where a written 0 clears a bit and a written 1 keeps it. Because of this, writing all ones except zeros in one channel's field acknowledges that channel and leaves the other channel's pending events in place. With the default width, that value is 0xFFFF0000 for channel 0 and 0x0000FFFF for channel 1. The mask register is an ordinary read/write register, and software normally enables a channel with a read-modify-write that ORs bits into its own field.

Suggested bit use inside a field: bit 0 end of descriptor, bit 1 end of chain, bit 2 channel stopped, bit 3 address-decode error, bits 4 to 9 other errors. The logic treats all bits alike.

Top module: `intc_cause_mask`

## Requirements
- R1: After a synchronous reset the cause register, the mask register, every interrupt output and the read data are all zero.
- R2: An event input bit that is high at a clock edge sets the matching cause bit at that edge, and the bit stays set until it is cleared.
- R3: A write to the cause register (address 0) clears each cause bit whose written bit is 0 and leaves unchanged each cause bit whose written bit is 1.
- R4: Channel n owns bits [16n+15:16n] of both registers. Writing all ones except zeros in channel n's field clears only channel n's cause bits.
- R5: When an event and a clearing write hit the same cause bit at one edge, the bit ends up set.
- R6: A write to the mask register (address 1) loads the written value, and the mask holds its value in every cycle without such a write.
- R7: Interrupt output n is registered. It is high one cycle after any bit of channel n's field is set in both the cause and the mask registers.
- R8: A read presents the selected register (address 0 cause, 1 mask) on the read data in the cycle after the read is requested. The value shown is the register contents before any update made at that same edge.
- R9: A write to the mask register has no effect on the cause register, and a write to the cause register has no effect on the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCH*FW | Event pulses; channel n uses bits [FW*n+FW-1:FW*n] |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 cause, 1 mask |
| wr_data_i | input | NCH*FW | Write data |
| rd_data_o | output | NCH*FW | Registered read data |
| irq_o | output | NCH | Registered per-channel interrupt |

## Verification
A single event bit is walked across all 32 positions. At each position the bench checks four things: the bit appears only where it belongs, it raises no interrupt while its mask bit is clear, it raises the interrupt of the right channel once the mask bit is set, and a write of zero at that position clears only that bit. Field-wide patterns (all ones, then per-channel clear values) separate one channel's acknowledge from the other channel's state. Writes of all ones show that the hold behaviour is correct. An event that lands on the same edge as a clearing write shows that the event has priority. Alternating mask and cause writes show that each register is unaffected by writes to the other.

// File: rtl/intc_cm_pkg.sv
package intc_cm_pkg;
  typedef enum logic {
    SEL_CAUSE = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;

  // Suggested event positions inside one channel field
  localparam int EV_DESC_DONE  = 0;
  localparam int EV_CHAIN_DONE = 1;
  localparam int EV_HALTED     = 2;
  localparam int EV_DECODE_ERR = 3;
  localparam int EV_ERR_FIRST  = 4;
  localparam int EV_ERR_LAST   = 9;
endpackage

// File: rtl/intc_cm_cause_field.sv
module intc_cm_cause_field #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  input  logic [FW-1:0] evt,
  output logic [FW-1:0] cause_o
);
  logic [FW-1:0] cause_q;
  logic [FW-1:0] kept;

  // written 0 clears, written 1 keeps
  always_comb begin
    kept = wr_en ? (cause_q & wr_data) : cause_q;
  end

  // events OR in after the clear, so a colliding event wins
  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= kept | evt;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/intc_cm_mask_field.sv
module intc_cm_mask_field #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  output logic [FW-1:0] mask_o
);
  logic [FW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/intc_cm_irq_reduce.sv
module intc_cm_irq_reduce #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] cause,
  input  logic [FW-1:0] mask,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(cause & mask);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/intc_cause_mask.sv
module intc_cause_mask
  import intc_cm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int FW  = 16,
  localparam int REG_W = NCH * FW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [NCH-1:0]   irq_o
);
  logic [REG_W-1:0] cause_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] rd_q;
  logic             wr_cause;
  logic             wr_mask;

  assign wr_cause = wr_en_i && (addr_i == SEL_CAUSE);
  assign wr_mask  = wr_en_i && (addr_i == SEL_MASK);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    intc_cm_cause_field #(.FW(FW)) u_cause (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_cause),
      .wr_data (wr_data_i[ch*FW +: FW]),
      .evt     (evt_i[ch*FW +: FW]),
      .cause_o (cause_q[ch*FW +: FW])
    );

    intc_cm_mask_field #(.FW(FW)) u_mask (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_mask),
      .wr_data (wr_data_i[ch*FW +: FW]),
      .mask_o  (mask_q[ch*FW +: FW])
    );

    intc_cm_irq_reduce #(.FW(FW)) u_irq (
      .clk   (clk),
      .rst   (rst),
      .cause (cause_q[ch*FW +: FW]),
      .mask  (mask_q[ch*FW +: FW]),
      .irq_o (irq_o[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= (addr_i == SEL_MASK) ? mask_q : cause_q;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/intc_cause_mask_chk.sv
module intc_cause_mask_chk #(
  parameter int NCH = 2,
  parameter int FW  = 16,
  localparam int REG_W = NCH * FW
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] evt_i,
  input logic             wr_en_i,
  input logic             addr_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] cause_q,
  input logic [REG_W-1:0] mask_q,
  input logic [NCH-1:0]   irq_o
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && mask_q == '0 && irq_o == '0)); // R1

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en_i && !addr_i) && evt_i == '0) |=> $stable(cause_q)); // R3

  AST_CAUSE_W0C: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !addr_i && evt_i == '0) |=>
      (cause_q == ($past(cause_q) & $past(wr_data_i)))); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && addr_i) |=> $stable(mask_q)); // R6

  for (genvar ch = 0; ch < NCH; ch++) begin : g_irq
    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_o[ch] ==
        |($past(cause_q[ch*FW +: FW]) & $past(mask_q[ch*FW +: FW])))); // R7
  end
endmodule

bind intc_cause_mask intc_cause_mask_chk #(.NCH(NCH), .FW(FW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/tb_intc_cause_mask.sv
module tb_intc_cause_mask;
  localparam int NCH = 2;
  localparam int FW  = 16;
  localparam int W   = NCH * FW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] evt_i = '0;
  logic         wr_en_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic         addr_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic [NCH-1:0] irq_o;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m_cause = '0;
  logic [W-1:0] m_mask  = '0;

  always #5 clk = ~clk;

  intc_cause_mask #(.NCH(NCH), .FW(FW)) dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] exp_irq();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = |(m_cause[c*FW +: FW] & m_mask[c*FW +: FW]);
    return r;
  endfunction

  // one edge with the given strobes; inputs change at negedge
  task automatic step(input logic [W-1:0] ev, input logic we, input logic a, input logic [W-1:0] d);
    evt_i = ev; wr_en_i = we; addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0;
    if (we && !a) m_cause = m_cause & d;
    if (we && a)  m_mask  = d;
    m_cause = m_cause | ev;
  endtask

  task automatic rd(input logic a, output logic [W-1:0] v);
    rd_en_i = 1'b1; addr_i = a;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
    v = rd_data_o;
  endtask

  // R8 reads; R7 irq settled by the time the first read returns
  task automatic check_all(input string req);
    logic [W-1:0] v;
    rd(1'b0, v); chk({req, " R8 cause"}, v, m_cause);
    chk({req, " R7 irq"}, W'(irq_o), W'(exp_irq()));
    rd(1'b1, v); chk({req, " R8 mask"}, v, m_mask);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", W'(irq_o), '0);
    chk("R1 rd_data", rd_data_o, '0);
    check_all("R1");

    // walking single bit over both channel fields: R2 R3 R4 R7 R9
    for (int b = 0; b < W; b++) begin
      step(W'(1) << b, 1'b0, 1'b0, '0);
      check_all("R2 R4");
      step('0, 1'b1, 1'b1, W'(1) << b);
      check_all("R6 R7 R9");
      step('0, 1'b1, 1'b1, '0);
      step('0, 1'b1, 1'b0, ~(W'(1) << b));
      check_all("R3 R9");
    end

    // set every bit, write all ones: hold (R3)
    step('1, 1'b0, 1'b0, '0);
    step('0, 1'b1, 1'b1, 32'h0001_0001);
    step('0, 1'b1, 1'b0, '1);
    check_all("R3 hold");
    // clear channel 0 only (R4)
    step('0, 1'b1, 1'b0, 32'hFFFF_0000);
    check_all("R4 ch0 clear");
    chk("R4 cause", m_cause, 32'hFFFF_0000);
    // clear channel 1 only (R4)
    step('0, 1'b1, 1'b0, 32'h0000_FFFF);
    check_all("R4 ch1 clear");

    // event collides with clearing write (R5)
    step(32'h0008_0004, 1'b0, 1'b0, '0);
    step(32'h0008_0000, 1'b1, 1'b0, 32'h0000_0000);
    check_all("R5 collide");
    chk("R5 bit", m_cause, 32'h0008_0000);

    // read returns pre-update value (R8)
    evt_i = 32'h0000_0020; rd_en_i = 1'b1; addr_i = 1'b0;
    @(posedge clk); @(negedge clk);
    evt_i = '0; rd_en_i = 1'b0;
    chk("R8 old value", rd_data_o, m_cause);
    m_cause = m_cause | 32'h0000_0020;
    check_all("R8 after");

    // mid-run reset (R1)
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    m_cause = '0; m_mask = '0;
    chk("R1 irq again", W'(irq_o), '0);
    check_all("R1 again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule